// File: doc/BRIEF.md
# Interrupt Request Latch Controller

This block keeps the pending-interrupt state of a small 8-bit controller. Eight request bits are set by single-cycle pulses from hardware sources and by software, and they are cleared by software or when the CPU acknowledges the request it is servicing. An enable mask gates the pending bits. A fixed-priority selector then presents one request, valid flag and 3-bit number, to the CPU. Software can set or clear any group of bits in one write cycle, so a hardware pulse that arrives during the update is never lost.

One source is a watchdog timeout that lives in a slower clock domain. Its flag is set and held while the timeout level persists, and it reaches the system domain through a synchronizer. While the synchronized flag is high it sets its pending bit again every system cycle. Reading the status register asks the slow domain to drop the flag. The request crosses with a toggle, and the slow domain confirms with a returned toggle. While a clear is still in flight, further status reads do not start another one.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset the pending bits, the enable bits and the status flag (status bit 5) read 0, and irq_valid is 0.
- R2: req_wr_op = 0 loads req_wr_data into the pending bits in the next cycle. op 3 is no write.
- R3: req_wr_op = 1 ORs req_wr_data into the pending bits in one cycle, and leaves every other bit unchanged.
- R4: req_wr_op = 2 clears the pending bits where req_wr_data is 1, and leaves every other bit unchanged.
- R5: A bit of hw_req high at a clock edge is pending after that edge. This holds even if the same edge carries a load, a clear or an acknowledge of that bit.
- R6: ack_valid with ack_id = k clears only pending bit k.
- R7: irq_valid is 1 exactly when some bit is both pending and enabled. irq_id is then the lowest such bit number. A pending bit whose enable is 0 raises nothing.
- R8: en_wr loads en_wr_data into the enable bits in the next cycle.
- R9: A watchdog timeout held in the slow domain sets status bit 5 within a bounded number of system cycles. While bit 5 is 1, pending bit 5 is set again every cycle, so an acknowledge does not keep it clear.
- R10: A status read drops status bit 5 within a bounded time once the timeout has ended. While the timeout is still held, the flag stays 1 after reads.
- R11: A cycle with no write, no acknowledge and no hardware request leaves the pending bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, system domain |
| wdt_clk | input | 1 | Slow watchdog-domain clock |
| wdt_rst | input | 1 | Synchronous active-high reset, watchdog domain |
| wdt_timeout | input | 1 | Timeout level, synchronous to wdt_clk |
| hw_req | input | 8 | Single-cycle request pulses from hardware sources |
| req_wr_op | input | 2 | Pending write: 0 load, 1 OR-set, 2 AND-clear, 3 none |
| req_wr_data | input | 8 | Data or mask for the pending write |
| en_wr | input | 1 | Load the enable register |
| en_wr_data | input | 8 | New enable mask |
| ack_valid | input | 1 | CPU acknowledges a request |
| ack_id | input | 3 | Number of the acknowledged request |
| stat_rd | input | 1 | Status register read strobe, clears the watchdog flag |
| stat_data | output | 8 | Status register, bit 5 is the watchdog flag |
| req_rd_data | output | 8 | Current pending bits |
| en_rd_data | output | 8 | Current enable bits |
| irq_valid | output | 1 | A pending, enabled request exists |
| irq_id | output | 3 | Number of the selected request |

## Verification
A wrong pending bit shows on req_rd_data, and on irq_valid or irq_id when it is enabled, in the cycle after the edge that stored it. The bench compares these every cycle with a behavioural model, so an error in the update order (write, then acknowledge, then hardware set) is caught within one cycle. A fault in the crossing shows as status bit 5 that rises late, never falls, or falls while the timeout is held. The bench bounds these windows in system cycles. It also feeds the observed flag into its model, so a pending bit 5 that is not set again diverges at once.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int unsigned NSRC         = 8;
    localparam int unsigned ID_W         = $clog2(NSRC);
    localparam int unsigned STAT_W       = 8;
    localparam int unsigned STAT_WDT_BIT = 5;
    localparam int unsigned WDT_SRC      = 5;

    typedef enum logic [1:0] {
        REQ_WR_LOAD = 2'd0,
        REQ_WR_SET  = 2'd1,
        REQ_WR_CLR  = 2'd2,
        REQ_WR_NOP  = 2'd3
    } req_wr_op_e;

    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] id;
    } irq_sel_t;

    // Lowest set bit wins; scan from the top so the last hit is the lowest.
    function automatic irq_sel_t pick_lowest(input logic [NSRC-1:0] vec);
        irq_sel_t r;
        r.valid = 1'b0;
        r.id    = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (vec[i]) begin
                r.valid = 1'b1;
                r.id    = ID_W'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_wdt_cdc.sv
module irq_wdt_cdc #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic wdt_clk,
    input  logic wdt_rst,
    input  logic wdt_timeout,
    input  logic stat_rd,
    output logic flag_sync
);
    localparam int unsigned MSB = SYNC_STAGES - 1;

    // ---------------- slow domain ----------------
    logic                   flag_q;
    logic                   seen_q;
    logic [SYNC_STAGES-1:0] tgl_sync_q;
    logic                   clr_hit;

    assign clr_hit = tgl_sync_q[MSB] ^ seen_q;

    always_ff @(posedge wdt_clk) begin
        if (wdt_rst) begin
            flag_q     <= 1'b0;
            seen_q     <= 1'b0;
            tgl_sync_q <= '0;
        end else begin
            tgl_sync_q <= {tgl_sync_q[SYNC_STAGES-2:0], clr_tgl_q};
            seen_q     <= tgl_sync_q[MSB];
            // a held timeout overrides the clear request
            flag_q     <= wdt_timeout | (flag_q & ~clr_hit);
        end
    end

    // ---------------- system domain ----------------
    logic [SYNC_STAGES-1:0] flag_sync_q;
    logic [SYNC_STAGES-1:0] ack_sync_q;
    logic                   clr_tgl_q;
    logic                   busy;

    assign busy      = clr_tgl_q ^ ack_sync_q[MSB];
    assign flag_sync = flag_sync_q[MSB];

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_sync_q <= '0;
            ack_sync_q  <= '0;
            clr_tgl_q   <= 1'b0;
        end else begin
            flag_sync_q <= {flag_sync_q[SYNC_STAGES-2:0], flag_q};
            ack_sync_q  <= {ack_sync_q[SYNC_STAGES-2:0], seen_q};
            if (stat_rd && !busy)
                clr_tgl_q <= ~clr_tgl_q;
        end
    end

    // R9: a timeout seen at a slow edge leaves the flag set after it
    assert_timeout_sets_flag_R9: assert property (
        @(posedge wdt_clk) disable iff (wdt_rst)
        wdt_timeout |=> flag_q
    );

    // R10: only one clear toggle in flight at a time
    assert_single_clear_in_flight_R10: assert property (
        @(posedge clk) disable iff (rst)
        busy |=> $stable(clr_tgl_q)
    );

endmodule

// File: rtl/irq_req_reg.sv
module irq_req_reg
    import irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  req_wr_op_e            wr_op,
    input  logic [NSRC-1:0]       wr_data,
    input  logic                  ack_valid,
    input  logic [ID_W-1:0]       ack_id,
    input  logic [NSRC-1:0]       hw_in,
    output logic [NSRC-1:0]       pend_q
);
    logic [NSRC-1:0] after_wr;
    logic [NSRC-1:0] after_ack;
    logic [NSRC-1:0] pend_d;

    always_comb begin
        unique case (wr_op)
            REQ_WR_LOAD: after_wr = wr_data;
            REQ_WR_SET:  after_wr = pend_q | wr_data;
            REQ_WR_CLR:  after_wr = pend_q & ~wr_data;
            default:     after_wr = pend_q;
        endcase
        after_ack = after_wr;
        if (ack_valid)
            after_ack[ack_id] = 1'b0;
        // hardware set has the last word
        pend_d = after_ack | hw_in;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    assert_hw_wins_R5: assert property (
        @(posedge clk) disable iff (rst)
        (|hw_in) |=> ((pend_q & $past(hw_in)) == $past(hw_in))
    );

    assert_ack_clears_R6: assert property (
        @(posedge clk) disable iff (rst)
        (ack_valid && wr_op == REQ_WR_NOP && !hw_in[ack_id]) |=> !pend_q[$past(ack_id)]
    );

    assert_set_keeps_R3: assert property (
        @(posedge clk) disable iff (rst)
        (wr_op == REQ_WR_SET && !ack_valid) |=> ((pend_q & $past(pend_q)) == $past(pend_q))
    );

    assert_idle_stable_R11: assert property (
        @(posedge clk) disable iff (rst)
        (wr_op == REQ_WR_NOP && !ack_valid && hw_in == '0) |=> $stable(pend_q)
    );

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] en,
    output irq_sel_t        sel
);
    logic [NSRC-1:0] live;

    assign live = pend & en;
    assign sel  = pick_lowest(live);

    assert_valid_only_if_enabled_R7: assert property (
        @(posedge clk) disable iff (rst)
        sel.valid |-> (pend[sel.id] && en[sel.id])
    );

    assert_none_lower_R7: assert property (
        @(posedge clk) disable iff (rst)
        sel.valid |-> ((pend & en & ((NSRC'(1) << sel.id) - NSRC'(1))) == '0)
    );

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wdt_clk,
    input  logic                  wdt_rst,
    input  logic                  wdt_timeout,
    input  logic [NSRC-1:0]       hw_req,
    input  logic [1:0]            req_wr_op,
    input  logic [NSRC-1:0]       req_wr_data,
    input  logic                  en_wr,
    input  logic [NSRC-1:0]       en_wr_data,
    input  logic                  ack_valid,
    input  logic [ID_W-1:0]       ack_id,
    input  logic                  stat_rd,
    output logic [STAT_W-1:0]     stat_data,
    output logic [NSRC-1:0]       req_rd_data,
    output logic [NSRC-1:0]       en_rd_data,
    output logic                  irq_valid,
    output logic [ID_W-1:0]       irq_id
);
    logic            wdt_flag;
    logic [NSRC-1:0] hw_all;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] pend;
    irq_sel_t        sel;

    irq_wdt_cdc #(.SYNC_STAGES(SYNC_STAGES)) u_cdc (
        .clk         (clk),
        .rst         (rst),
        .wdt_clk     (wdt_clk),
        .wdt_rst     (wdt_rst),
        .wdt_timeout (wdt_timeout),
        .stat_rd     (stat_rd),
        .flag_sync   (wdt_flag)
    );

    // level-held watchdog source re-sets its bit every cycle
    always_comb begin
        hw_all          = hw_req;
        hw_all[WDT_SRC] = hw_req[WDT_SRC] | wdt_flag;
    end

    irq_req_reg u_req (
        .clk       (clk),
        .rst       (rst),
        .wr_op     (req_wr_op_e'(req_wr_op)),
        .wr_data   (req_wr_data),
        .ack_valid (ack_valid),
        .ack_id    (ack_id),
        .hw_in     (hw_all),
        .pend_q    (pend)
    );

    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (en_wr) en_q <= en_wr_data;
    end

    irq_prio_sel u_sel (
        .clk  (clk),
        .rst  (rst),
        .pend (pend),
        .en   (en_q),
        .sel  (sel)
    );

    always_comb begin
        stat_data               = '0;
        stat_data[STAT_WDT_BIT] = wdt_flag;
    end

    assign req_rd_data = pend;
    assign en_rd_data  = en_q;
    assign irq_valid   = sel.valid;
    assign irq_id      = sel.id;

    assert_wdt_reasserts_R9: assert property (
        @(posedge clk) disable iff (rst)
        stat_data[STAT_WDT_BIT] |=> req_rd_data[WDT_SRC]
    );

    assert_enable_load_R8: assert property (
        @(posedge clk) disable iff (rst)
        en_wr |=> (en_rd_data == $past(en_wr_data))
    );

endmodule

// File: tb/tb_irq_latch_ctrl.sv
module tb_irq_latch_ctrl;

    localparam time CLK_PERIOD = 10ns;
    localparam time WDT_PERIOD = 70ns;
    localparam int  FLAG_WAIT  = 60;

    logic       clk = 1'b0;
    logic       wdt_clk = 1'b0;
    logic       rst, wdt_rst, wdt_timeout, wdt_want;
    logic [7:0] hw_req, req_wr_data, en_wr_data;
    logic [1:0] req_wr_op;
    logic       en_wr, ack_valid, stat_rd;
    logic [2:0] ack_id;
    logic [7:0] stat_data, req_rd_data, en_rd_data;
    logic       irq_valid;
    logic [2:0] irq_id;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] m_pend, m_en;
    string tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(WDT_PERIOD/2) wdt_clk = ~wdt_clk;
    always @(negedge wdt_clk) wdt_timeout <= wdt_want;

    irq_latch_ctrl dut (
        .clk(clk), .rst(rst), .wdt_clk(wdt_clk), .wdt_rst(wdt_rst),
        .wdt_timeout(wdt_timeout), .hw_req(hw_req), .req_wr_op(req_wr_op),
        .req_wr_data(req_wr_data), .en_wr(en_wr), .en_wr_data(en_wr_data),
        .ack_valid(ack_valid), .ack_id(ack_id), .stat_rd(stat_rd),
        .stat_data(stat_data), .req_rd_data(req_rd_data), .en_rd_data(en_rd_data),
        .irq_valid(irq_valid), .irq_id(irq_id)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        hw_req = '0; req_wr_op = 2'd3; req_wr_data = '0; en_wr = 1'b0;
        en_wr_data = '0; ack_valid = 1'b0; ack_id = '0; stat_rd = 1'b0;
    endtask

    task automatic compare_all();
        logic       ev;
        logic [2:0] eid;
        ev = 1'b0; eid = '0;
        for (int i = 7; i >= 0; i--)
            if (m_pend[i] && m_en[i]) begin ev = 1'b1; eid = 3'(i); end
        check(req_rd_data == m_pend, tag, "pending", int'(req_rd_data), int'(m_pend));
        check(en_rd_data == m_en, tag, "enable", int'(en_rd_data), int'(m_en));
        check(irq_valid == ev, tag, "irq_valid", int'(irq_valid), int'(ev));
        if (ev) check(irq_id == eid, tag, "irq_id", int'(irq_id), int'(eid));
    endtask

    // one system cycle: model next state from inputs held at the edge
    task automatic step();
        logic [7:0] nx, ne;
        nx = m_pend;
        case (req_wr_op)
            2'd0: nx = req_wr_data;
            2'd1: nx = nx | req_wr_data;
            2'd2: nx = nx & ~req_wr_data;
            default: ;
        endcase
        if (ack_valid) nx[ack_id] = 1'b0;
        nx = nx | hw_req;
        if (stat_data[5]) nx[5] = 1'b1;
        ne = en_wr ? en_wr_data : m_en;
        @(posedge clk);
        #1;
        m_pend = nx;
        m_en   = ne;
        compare_all();
        idle();
    endtask

    initial begin
        #(200000 * CLK_PERIOD);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        idle();
        wdt_want = 1'b0; wdt_timeout = 1'b0;
        rst = 1'b1; wdt_rst = 1'b1;
        repeat (4) @(posedge wdt_clk);
        @(negedge clk);
        rst = 1'b0; wdt_rst = 1'b0;
        #1;
        m_pend = '0; m_en = '0;
        // R1 reset state
        tag = "R1";
        compare_all();
        check(stat_data == 8'h00, "R1", "status", int'(stat_data), 0);
        check(irq_valid == 1'b0, "R1", "irq_valid", int'(irq_valid), 0);
        step();

        // R2 load, R8 enable
        tag = "R2"; req_wr_op = 2'd0; req_wr_data = 8'hA4; step();
        check(req_rd_data == 8'hA4, "R2", "load", int'(req_rd_data), 'hA4);
        tag = "R7"; check(irq_valid == 1'b0, "R7", "pending without enable", int'(irq_valid), 0);
        tag = "R8"; en_wr = 1'b1; en_wr_data = 8'hF0; step();
        check(en_rd_data == 8'hF0, "R8", "enable load", int'(en_rd_data), 'hF0);
        check(irq_valid && irq_id == 3'd5, "R7", "lowest enabled", int'(irq_id), 5);
        // R3 set mask
        tag = "R3"; req_wr_op = 2'd1; req_wr_data = 8'h12; step();
        check(req_rd_data == 8'hB6, "R3", "or-set", int'(req_rd_data), 'hB6);
        tag = "R7"; en_wr = 1'b1; en_wr_data = 8'hFF; step();
        check(irq_id == 3'd1, "R7", "priority", int'(irq_id), 1);
        // R4 clear mask
        tag = "R4"; req_wr_op = 2'd2; req_wr_data = 8'h06; step();
        check(req_rd_data == 8'hB0, "R4", "and-clear", int'(req_rd_data), 'hB0);
        // R6 ack clears one bit
        tag = "R6"; ack_valid = 1'b1; ack_id = 3'd4; step();
        check(req_rd_data == 8'hA0, "R6", "ack", int'(req_rd_data), 'hA0);
        // R5 hw wins over clear, ack and load of the same bit
        tag = "R5"; req_wr_op = 2'd2; req_wr_data = 8'h20; hw_req = 8'h20; step();
        check(req_rd_data[5], "R5", "hw vs clear", int'(req_rd_data), 'hA0);
        ack_valid = 1'b1; ack_id = 3'd7; hw_req = 8'h80; step();
        check(req_rd_data[7], "R5", "hw vs ack", int'(req_rd_data), 'hA0);
        req_wr_op = 2'd0; req_wr_data = 8'h00; hw_req = 8'h01; step();
        check(req_rd_data == 8'h01, "R5", "hw vs load", int'(req_rd_data), 1);
        // R11 idle holds
        tag = "R11"; repeat (5) step();
        check(req_rd_data == 8'h01, "R11", "idle hold", int'(req_rd_data), 1);

        // random mixed traffic, timeout off
        tag = "R2/R3/R4/R5/R6/R7/R8/R11";
        for (int c = 0; c < 3000; c++) begin
            for (int b = 0; b < 8; b++) hw_req[b] = ($urandom % 8) == 0;
            req_wr_op   = 2'($urandom);
            req_wr_data = 8'($urandom);
            ack_valid   = ($urandom % 3) == 0;
            ack_id      = 3'($urandom);
            en_wr       = ($urandom % 16) == 0;
            en_wr_data  = 8'($urandom);
            step();
        end

        // R9 watchdog flag crossing
        tag = "R9";
        req_wr_op = 2'd0; req_wr_data = 8'h00; step();
        wdt_want = 1'b1;
        begin
            int w = 0;
            while (!stat_data[5] && w < FLAG_WAIT) begin step(); w++; end
            check(stat_data[5] == 1'b1, "R9", "flag rises", int'(stat_data), 'h20);
        end
        step();
        check(req_rd_data[5], "R9", "pending set by flag", int'(req_rd_data), 'h20);
        ack_valid = 1'b1; ack_id = 3'd5; step();
        check(req_rd_data[5], "R9", "re-set after ack", int'(req_rd_data), 'h20);

        // R10 read while held keeps the flag
        tag = "R10";
        stat_rd = 1'b1; step();
        repeat (FLAG_WAIT) step();
        check(stat_data[5] == 1'b1, "R10", "held flag survives read", int'(stat_data), 'h20);
        wdt_want = 1'b0;
        repeat (30) step();
        check(stat_data[5] == 1'b1, "R10", "flag held until read", int'(stat_data), 'h20);
        begin
            int w = 0;
            stat_rd = 1'b1; step();
            while (stat_data[5] && w < FLAG_WAIT) begin
                if (w % 4 == 0) stat_rd = 1'b1;
                step(); w++;
            end
            check(stat_data[5] == 1'b0, "R10", "flag cleared by read", int'(stat_data), 0);
        end
        ack_valid = 1'b1; ack_id = 3'd5; step();
        repeat (3) step();
        check(req_rd_data[5] == 1'b0, "R10", "bit stays clear", int'(req_rd_data), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule